// File: doc/BRIEF.md
# Converter Calibration Control Sequencer

This block decides when a data converter runs its self-calibration and tells the rest of the converter when to stop. After power is applied (modelled by a synchronous active-high reset) it waits a settling delay and then starts one automatic calibration. The delay is one of two values, chosen by a select input that is captured during reset. Software or board logic can also ask for a calibration through a single command pin. That request counts only if the pin is held low for a minimum number of cycles and then held high for a minimum number of cycles.

While a calibration runs, the block raises a busy output, drops the enable for the internal and output clocks, and marks the output data and the out-of-range flag as invalid. The power-down input takes precedence over everything else. It freezes the power-up delay, blocks any start, and aborts a calibration that is already running. If the command pin is high during reset, the automatic calibration is suppressed and only a qualified command can start one. The analog trimming is modelled as a run period of fixed length.

States: `ST_PU_DELAY` (settling wait), `ST_IDLE` (converting, waiting for a command), `ST_RUN` (calibrating). Transitions: reset with command pin low enters `ST_PU_DELAY`; reset with command pin high enters `ST_IDLE`; `ST_PU_DELAY`→`ST_RUN` on delay expiry or on a qualified command; `ST_IDLE`→`ST_RUN` on a qualified command; `ST_RUN`→`ST_IDLE` when the run period ends or, as an abort, when power-down is high.

Top module: `cal_sequencer`

## Requirements
- R1: While reset is high and on the first cycle after it, busy_o is 0 and clk_en_o and data_valid_o are 1.
- R2: With the command pin low and power-down low during reset, busy_o rises exactly DLY_SHORT cycles after reset is released when dly_sel_i was 0 during reset, and exactly DLY_LONG cycles after release when it was 1.
- R3: Every cycle in which pwr_dn_i is high during the settling wait is added to that wait, because the delay counter is frozen during those cycles.
- R4: If cal_cmd_i is 1 during reset, no automatic calibration starts.
- R5: cal_cmd_i at 0 for at least TCAL_L consecutive cycles, followed by cal_cmd_i at 1 for TCAL_H consecutive cycles, makes busy_o rise right after the TCAL_H-th high cycle.
- R6: A low phase shorter than TCAL_L, or a high phase that ends before TCAL_H cycles, starts nothing.
- R7: busy_o stays high for exactly RUN_LEN cycles unless the run is aborted. Whenever busy_o is 1, clk_en_o and data_valid_o are 0, and otherwise they are 1.
- R8: While pwr_dn_i is 1, no calibration starts, and no command cycle seen during that time counts toward a later request.
- R9: pwr_dn_i at 1 during a run clears busy_o on the next cycle, and no calibration follows without a new qualified command.
- R10: Command-pin activity during a run is ignored. Qualification restarts from nothing after busy_o falls.
- R11: The automatic calibration runs only once per reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset (power application) |
| cal_cmd_i | input | 1 | Calibration command pin (low then high) |
| dly_sel_i | input | 1 | Settling delay select, captured during reset |
| pwr_dn_i | input | 1 | Power-down request |
| busy_o | output | 1 | Calibration running |
| clk_en_o | output | 1 | Enable for internal and output clocks |
| data_valid_o | output | 1 | Output data and out-of-range flag are valid |

## Verification
The bench checks the settling delay at the exact cycle boundary for both select values. A counter that is off by one would raise busy a cycle early or late. It also holds power-down during the wait; a design that kept counting through power-down would start too soon. Command sequences that fall one cycle short in either phase must start nothing, and a design that counts total cycles instead of consecutive ones would start a calibration anyway. The bench also aborts a run with power-down and toggles the command pin during a run. A design that restarted after the abort, or that kept low-phase credit from inside the run, would raise busy where it must stay low.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

    typedef enum logic [1:0] {
        ST_PU_DELAY = 2'd0,
        ST_IDLE     = 2'd1,
        ST_RUN      = 2'd2
    } cal_state_t;

endpackage

// File: rtl/cal_pu_delay.sv
// Power-up settling counter: counts enabled cycles, limit chosen at reset.
module cal_pu_delay #(
    parameter int unsigned DLY_SHORT = 6,
    parameter int unsigned DLY_LONG  = 12
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic sel_i,
    input  logic count_en_i,
    output logic done_o
);
    localparam int unsigned DMAX = (DLY_LONG > DLY_SHORT) ? DLY_LONG : DLY_SHORT;
    localparam int unsigned CW   = $clog2(DMAX + 1);

    logic          sel_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    assign limit  = sel_q ? CW'(DLY_LONG - 1) : CW'(DLY_SHORT - 1);
    assign done_o = count_en_i && (cnt_q == limit);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sel_q <= sel_i;
            cnt_q <= '0;
        end else if (count_en_i && !done_o) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/cal_cmd_qual.sv
// Command qualifier: consecutive low cycles, then consecutive high cycles.
module cal_cmd_qual #(
    parameter int unsigned TCAL_L = 4,
    parameter int unsigned TCAL_H = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic en_i,
    input  logic cmd_i,
    output logic fire_o
);
    localparam int unsigned LW = $clog2(TCAL_L + 1);
    localparam int unsigned HW = $clog2(TCAL_H + 1);

    logic [LW-1:0] lo_q;
    logic [HW-1:0] hi_q;
    logic          lo_ok;

    assign lo_ok  = (lo_q == LW'(TCAL_L));
    assign fire_o = en_i && cmd_i && lo_ok && (hi_q == HW'(TCAL_H - 1));

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i || fire_o) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (cmd_i) begin
            if (lo_ok) begin
                hi_q <= hi_q + HW'(1);
            end else begin
                lo_q <= '0;
                hi_q <= '0;
            end
        end else begin
            hi_q <= '0;
            if (hi_q != '0) begin
                lo_q <= LW'(1);
            end else if (!lo_ok) begin
                lo_q <= lo_q + LW'(1);
            end
        end
    end
endmodule

// File: rtl/cal_run_timer.sv
// Fixed-length run period standing in for the analog trim.
module cal_run_timer #(
    parameter int unsigned RUN_LEN = 10
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    output logic done_o
);
    localparam int unsigned RW = $clog2(RUN_LEN + 1);

    logic [RW-1:0] cnt_q;

    assign done_o = run_i && (cnt_q == RW'(RUN_LEN - 1));

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i || done_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + RW'(1);
        end
    end
endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer #(
    parameter int unsigned TCAL_L    = 4,
    parameter int unsigned TCAL_H    = 4,
    parameter int unsigned DLY_SHORT = 6,
    parameter int unsigned DLY_LONG  = 12,
    parameter int unsigned RUN_LEN   = 10
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic cal_cmd_i,
    input  logic dly_sel_i,
    input  logic pwr_dn_i,
    output logic busy_o,
    output logic clk_en_o,
    output logic data_valid_o
);
    import cal_seq_pkg::*;

    cal_state_t state_q, state_d;
    logic       pu_done, cmd_fire, run_done;
    logic       pu_count_en, qual_en, running;

    assign running     = (state_q == ST_RUN);
    assign pu_count_en = (state_q == ST_PU_DELAY) && !pwr_dn_i;
    assign qual_en     = !running && !pwr_dn_i;

    cal_pu_delay #(.DLY_SHORT(DLY_SHORT), .DLY_LONG(DLY_LONG)) pu_i (
        .clk_i(clk_i), .rst_i(rst_i), .sel_i(dly_sel_i),
        .count_en_i(pu_count_en), .done_o(pu_done)
    );

    cal_cmd_qual #(.TCAL_L(TCAL_L), .TCAL_H(TCAL_H)) qual_i (
        .clk_i(clk_i), .rst_i(rst_i), .en_i(qual_en),
        .cmd_i(cal_cmd_i), .fire_o(cmd_fire)
    );

    cal_run_timer #(.RUN_LEN(RUN_LEN)) run_i (
        .clk_i(clk_i), .rst_i(rst_i), .run_i(running), .done_o(run_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PU_DELAY: begin
                if (!pwr_dn_i && (cmd_fire || pu_done)) state_d = ST_RUN;
            end
            ST_IDLE: begin
                if (cmd_fire) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (pwr_dn_i || run_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= cal_cmd_i ? ST_IDLE : ST_PU_DELAY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        busy_o       = running;
        clk_en_o     = !running;
        data_valid_o = !running;
    end
endmodule

// File: rtl/cal_sequencer_chk.sv
module cal_sequencer_chk #(
    parameter int unsigned RUN_LEN = 10
) (
    input logic clk_i,
    input logic rst_i,
    input logic pwr_dn_i,
    input logic busy_o,
    input logic clk_en_o,
    input logic data_valid_o
);
    localparam int unsigned BW = $clog2(RUN_LEN + 1) + 1;

    logic [BW-1:0] bcnt_q;
    logic          rst_q;

    always_ff @(posedge clk_i) begin
        rst_q <= rst_i;
        if (rst_i || !busy_o) bcnt_q <= '0;
        else                  bcnt_q <= bcnt_q + BW'(1);
    end

    always @(negedge clk_i) begin
        if (rst_q) begin
            assert_reset_idle_R1: assert (!busy_o && clk_en_o && data_valid_o);
        end
    end

    assert_gate_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_o |-> (!clk_en_o && !data_valid_o));

    assert_open_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !busy_o |-> (clk_en_o && data_valid_o));

    assert_run_max_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_o |-> (bcnt_q < BW'(RUN_LEN)));

    assert_run_end_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && bcnt_q == BW'(RUN_LEN - 1)) |=> !busy_o);

    assert_abort_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && pwr_dn_i) |=> !busy_o);

    assert_no_start_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (!busy_o && pwr_dn_i) |=> !busy_o);
endmodule

bind cal_sequencer cal_sequencer_chk #(.RUN_LEN(RUN_LEN)) chk_i (
    .clk_i(clk_i), .rst_i(rst_i), .pwr_dn_i(pwr_dn_i),
    .busy_o(busy_o), .clk_en_o(clk_en_o), .data_valid_o(data_valid_o)
);

// File: tb/cal_sequencer_tb.sv
module cal_sequencer_tb_top;
    localparam int TL = 4, TH = 4, DS = 6, DL = 12, RL = 10;

    logic clk = 1'b0, rst = 1'b1, cmd = 1'b0, sel = 1'b0, pd = 1'b0;
    logic busy, clk_en, valid;
    int   n_run = 0, n_fail = 0;
    bit   finished = 0;

    always #4 clk = ~clk;

    cal_sequencer #(.TCAL_L(TL), .TCAL_H(TH), .DLY_SHORT(DS), .DLY_LONG(DL), .RUN_LEN(RL)) dut_i (
        .clk_i(clk), .rst_i(rst), .cal_cmd_i(cmd), .dly_sel_i(sel), .pwr_dn_i(pd),
        .busy_o(busy), .clk_en_o(clk_en), .data_valid_o(valid)
    );

    typedef struct packed { logic [7:0] lo; logic [7:0] hi; logic ex; } vec_t;
    localparam vec_t VECS [6] = '{
        '{8'd4, 8'd4, 1'b1}, '{8'd6, 8'd4, 1'b1}, '{8'd4, 8'd7, 1'b1},
        '{8'd3, 8'd4, 1'b0}, '{8'd4, 8'd3, 1'b0}, '{8'd1, 8'd9, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic c, input logic s, input logic p);
        @(negedge clk);
        rst = 1'b1; cmd = c; sel = s; pd = p;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic stay_low(input int cyc, output int seen);
        seen = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (busy) seen = 1;
        end
    endtask

    task automatic cmd_seq(input int lo, input int hi);
        @(negedge clk);
        cmd = 1'b0;
        repeat (lo) @(posedge clk);
        @(negedge clk);
        cmd = 1'b1;
        repeat (hi) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        int n, seen;
        // R1: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 clk_en", clk_en, 1);
        chk("R1 valid", valid, 1);

        // Vector table: command qualification (R5, R6, R7)
        for (int v = 0; v < 6; v++) begin
            do_reset(1'b1, 1'b0, 1'b0);
            cmd_seq(int'(VECS[v].lo), int'(VECS[v].hi));
            chk(VECS[v].ex ? "R5 start" : "R6 reject", busy, int'(VECS[v].ex));
            cmd = 1'b0;
            if (VECS[v].ex) begin
                chk("R7 gated", {clk_en, valid}, 0);
                count_busy(n);
                chk("R7 run length", n, RL - (int'(VECS[v].hi) - TH));
                chk("R7 reopened", {clk_en, valid}, 3);
            end else begin
                stay_low(4, seen);
                chk("R6 no late start", seen, 0);
            end
        end

        // R2 short delay, then R11 once only
        do_reset(1'b0, 1'b0, 1'b0);
        repeat (DS - 1) @(posedge clk);
        @(negedge clk);
        chk("R2 short early", busy, 0);
        @(negedge clk);
        chk("R2 short edge", busy, 1);
        count_busy(n);
        chk("R7 auto length", n, RL);
        stay_low(2 * DL + RL, seen);
        chk("R11 once", seen, 0);

        // R2 long delay
        do_reset(1'b0, 1'b1, 1'b0);
        repeat (DL - 1) @(posedge clk);
        @(negedge clk);
        chk("R2 long early", busy, 0);
        @(negedge clk);
        chk("R2 long edge", busy, 1);
        count_busy(n);

        // R3: power-down freezes the delay
        do_reset(1'b0, 1'b0, 1'b1);
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R3 held", busy, 0);
        pd = 1'b0;
        repeat (DS - 1) @(posedge clk);
        @(negedge clk);
        chk("R3 early", busy, 0);
        @(negedge clk);
        chk("R3 edge", busy, 1);
        count_busy(n);

        // R4: command high at reset blocks auto calibration
        do_reset(1'b1, 1'b0, 1'b0);
        stay_low(DL + RL, seen);
        chk("R4 blocked", seen, 0);

        // R8: command during power-down does not count
        do_reset(1'b1, 1'b0, 1'b1);
        cmd_seq(TL, TH);
        chk("R8 no start", busy, 0);
        pd = 1'b0;
        stay_low(TH + 3, seen);
        chk("R8 no credit", seen, 0);

        // R9: abort by power-down
        do_reset(1'b1, 1'b0, 1'b0);
        cmd_seq(TL, TH);
        chk("R9 started", busy, 1);
        repeat (2) @(negedge clk);
        pd = 1'b1;
        @(negedge clk);
        chk("R9 aborted", busy, 0);
        pd = 1'b0;
        cmd = 1'b0;
        stay_low(DL + RL, seen);
        chk("R9 no restart", seen, 0);

        // R10: activity during a run is ignored
        do_reset(1'b1, 1'b0, 1'b0);
        cmd_seq(TL, TH);
        cmd = 1'b0;
        count_busy(n);
        cmd = 1'b1;
        stay_low(TH + 2, seen);
        chk("R10 no credit", seen, 0);
        cmd_seq(TL, TH);
        chk("R10 fresh start", busy, 1);
        cmd = 1'b0;
        count_busy(n);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule